// File: doc/BRIEF.md
# I2C Clock Phase Generator

This block produces the serial clock of an I2C controller from a core clock. When enabled, it alternates between a released (high) phase and a driven-low phase. The length of each phase comes from a pair of count registers. A two-bit speed field picks one of three pairs: standard, fast, or high-speed. The high phase also absorbs the active spike-filter length plus a fixed overhead of seven clocks. The low phase is its count plus one clock.

The bit engine is told where each phase begins through single-cycle strobes. It is also told, by a separate one-cycle pulse, when the SDA hold time after a falling SCL edge has elapsed, so data may then change. Both sampled bus lines pass through a glitch filter whose length follows the speed field. There is no data stream at this boundary: every pin is a plain control or status level, so no valid/ready handshake or back-pressure applies.

Top module: `scl_timegen`

## Requirements
- R1: While `enable` is low, `scl_oe` is 0 (SCL released) and `hi_strb`, `lo_strb` and `sda_ok` are 0; the first phase after `enable` rises is a high phase.
- R2: A high phase (`scl_oe` = 0) lasts HCNT + SPK + 7 core clocks, where HCNT and SPK are the values selected for that phase.
- R3: A low phase (`scl_oe` = 1) lasts LCNT + 1 core clocks.
- R4: `mode` value 3 selects the `hs_*` count pair, value 2 selects the `fs_*` pair, and values 1 and 0 select the `ss_*` pair.
- R5: The active spike length SPK is `hs_spklen` when `mode` is 3, and `fs_spklen` otherwise; it applies to both phase timing and the line filters.
- R6: Counts and mode are sampled only on the clock edge that starts a phase; a change during a phase takes effect at the next phase start.
- R7: `hi_strb` is high for exactly the first cycle of every high phase, and `lo_strb` for exactly the first cycle of every low phase; they are never high together.
- R8: `sda_ok` pulses for one cycle exactly `sda_hold` cycles after the first cycle of a low phase (the same cycle when `sda_hold` is 0).
- R9: `scl_filt`/`sda_filt` reset to 1 and take a new value only after the raw input has differed from them for max(SPK,1) consecutive samples; shorter pulses are ignored.
- R10: Lowering `enable` mid-phase releases SCL and clears the counters on the next cycle; re-enabling starts a full-length high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable |
| mode | input | 2 | Speed class select |
| ss_hcnt | input | CW | Standard high count |
| ss_lcnt | input | CW | Standard low count |
| fs_hcnt | input | CW | Fast high count |
| fs_lcnt | input | CW | Fast low count |
| hs_hcnt | input | CW | High-speed high count |
| hs_lcnt | input | CW | High-speed low count |
| fs_spklen | input | SW | Spike length for standard and fast classes |
| hs_spklen | input | SW | Spike length for high-speed class |
| sda_hold | input | HW | SDA hold delay in core clocks |
| scl_in | input | 1 | Raw sampled SCL |
| sda_in | input | 1 | Raw sampled SDA |
| scl_oe | output | 1 | 1 drives SCL low |
| hi_strb | output | 1 | First cycle of a high phase |
| lo_strb | output | 1 | First cycle of a low phase |
| sda_ok | output | 1 | SDA hold time elapsed |
| scl_filt | output | 1 | Filtered SCL |
| sda_filt | output | 1 | Filtered SDA |

## Verification
The hardest case to reach is a count or mode change that lands inside a running phase. It must not shorten or stretch that phase, yet it must govern the next one. The stimulus waits on `lo_strb`, rewrites the low count in that same cycle, and then measures both the current low phase and the one after it. A disable issued in the first low cycle, and filter pulses exactly one sample shorter than the spike length and exactly equal to it, are reached the same way, by aligning stimulus to the strobes.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
  typedef enum logic [1:0] {
    SPD_RSVD = 2'd0,
    SPD_STD  = 2'd1,
    SPD_FAST = 2'd2,
    SPD_HIGH = 2'd3
  } spd_e;

  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } phase_e;

  localparam int unsigned HI_OVERHEAD = 7;
endpackage

// File: rtl/scl_tg_sel.sv
module scl_tg_sel
  import scl_tg_pkg::*;
#(
  parameter int CW = 16,
  parameter int SW = 8,
  parameter int LW = 18
) (
  input  logic [1:0]    mode,
  input  logic [CW-1:0] ss_h,
  input  logic [CW-1:0] ss_l,
  input  logic [CW-1:0] fs_h,
  input  logic [CW-1:0] fs_l,
  input  logic [CW-1:0] hs_h,
  input  logic [CW-1:0] hs_l,
  input  logic [SW-1:0] fs_spk,
  input  logic [SW-1:0] hs_spk,
  output logic [LW-1:0] hi_len,
  output logic [LW-1:0] lo_len,
  output logic [SW-1:0] spk
);
  logic [CW-1:0] h_sel, l_sel;

  always_comb begin
    unique case (spd_e'(mode))
      SPD_HIGH: begin h_sel = hs_h; l_sel = hs_l; spk = hs_spk; end
      SPD_FAST: begin h_sel = fs_h; l_sel = fs_l; spk = fs_spk; end
      default:  begin h_sel = ss_h; l_sel = ss_l; spk = fs_spk; end
    endcase
    hi_len = LW'(h_sel) + LW'(spk) + LW'(HI_OVERHEAD);
    lo_len = LW'(l_sel) + LW'(1);
  end
endmodule

// File: rtl/scl_tg_phase.sv
module scl_tg_phase
  import scl_tg_pkg::*;
#(
  parameter int LW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [LW-1:0] hi_len,
  input  logic [LW-1:0] lo_len,
  output logic          enter_low,
  output logic          scl_oe,
  output logic          hi_strb,
  output logic          lo_strb
);
  logic          running;
  phase_e        phase;
  logic [LW-1:0] cnt;
  logic          start_q;

  assign enter_low = enable && running && (cnt == '0) && (phase == PH_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      phase   <= PH_HIGH;
      cnt     <= '0;
      start_q <= 1'b0;
    end else if (!enable) begin
      running <= 1'b0;
      phase   <= PH_HIGH;
      cnt     <= '0;
      start_q <= 1'b0;
    end else if (!running) begin
      running <= 1'b1;
      phase   <= PH_HIGH;
      cnt     <= hi_len - LW'(1);
      start_q <= 1'b1;
    end else if (cnt == '0) begin
      if (phase == PH_HIGH) begin
        phase <= PH_LOW;
        cnt   <= lo_len - LW'(1);
      end else begin
        phase <= PH_HIGH;
        cnt   <= hi_len - LW'(1);
      end
      start_q <= 1'b1;
    end else begin
      cnt     <= cnt - LW'(1);
      start_q <= 1'b0;
    end
  end

  assign scl_oe  = running && (phase == PH_LOW);
  assign hi_strb = start_q && running && (phase == PH_HIGH);
  assign lo_strb = start_q && (phase == PH_LOW);
endmodule

// File: rtl/scl_tg_hold.sv
module scl_tg_hold #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          load,
  input  logic [HW-1:0] hold_len,
  output logic          sda_ok
);
  logic          active;
  logic [HW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!enable) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= hold_len;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - HW'(1);
    end
  end

  assign sda_ok = active && (cnt == '0);
endmodule

// File: rtl/scl_tg_glitch.sv
module scl_tg_glitch #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw,
  input  logic [SW-1:0] spk,
  output logic          filt
);
  logic [SW-1:0] run;
  logic [SW:0]   run_next;

  assign run_next = {1'b0, run} + (SW+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt <= 1'b1;
      run  <= '0;
    end else if (raw == filt) begin
      run <= '0;
    end else if (run_next >= {1'b0, spk}) begin
      filt <= raw;
      run  <= '0;
    end else begin
      run <= run_next[SW-1:0];
    end
  end
endmodule

// File: rtl/scl_timegen.sv
module scl_timegen #(
  parameter int CW = 16,
  parameter int SW = 8,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] ss_hcnt,
  input  logic [CW-1:0] ss_lcnt,
  input  logic [CW-1:0] fs_hcnt,
  input  logic [CW-1:0] fs_lcnt,
  input  logic [CW-1:0] hs_hcnt,
  input  logic [CW-1:0] hs_lcnt,
  input  logic [SW-1:0] fs_spklen,
  input  logic [SW-1:0] hs_spklen,
  input  logic [HW-1:0] sda_hold,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          hi_strb,
  output logic          lo_strb,
  output logic          sda_ok,
  output logic          scl_filt,
  output logic          sda_filt
);
  localparam int LW     = ((CW > SW) ? CW : SW) + 2;
  localparam int NLINES = 2;

  logic [LW-1:0] hi_len, lo_len;
  logic [SW-1:0] spk;
  logic          enter_low;
  logic [NLINES-1:0] raw_v, filt_v;

  scl_tg_sel #(.CW(CW), .SW(SW), .LW(LW)) u_sel (
    .mode(mode), .ss_h(ss_hcnt), .ss_l(ss_lcnt), .fs_h(fs_hcnt), .fs_l(fs_lcnt),
    .hs_h(hs_hcnt), .hs_l(hs_lcnt), .fs_spk(fs_spklen), .hs_spk(hs_spklen),
    .hi_len(hi_len), .lo_len(lo_len), .spk(spk)
  );

  scl_tg_phase #(.LW(LW)) u_phase (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hi_len(hi_len), .lo_len(lo_len),
    .enter_low(enter_low), .scl_oe(scl_oe), .hi_strb(hi_strb), .lo_strb(lo_strb)
  );

  scl_tg_hold #(.HW(HW)) u_hold (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load(enter_low),
    .hold_len(sda_hold), .sda_ok(sda_ok)
  );

  assign raw_v = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    scl_tg_glitch #(.SW(SW)) u_glitch (
      .clk(clk), .rst_n(rst_n), .raw(raw_v[g]), .spk(spk), .filt(filt_v[g])
    );
  end

  assign scl_filt = filt_v[0];
  assign sda_filt = filt_v[1];
endmodule

// File: rtl/scl_tg_chk.sv
module scl_tg_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_in,
  input logic sda_in,
  input logic scl_oe,
  input logic hi_strb,
  input logic lo_strb,
  input logic sda_ok,
  input logic scl_filt,
  input logic sda_filt
);
  p_off_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_oe && !hi_strb && !lo_strb && !sda_ok));

  p_fall_marks_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> lo_strb);

  p_rise_marks_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_oe) && $past(enable)) |-> hi_strb);

  p_strobes_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_strb, lo_strb}));

  p_low_strobe_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_strb |-> scl_oe);

  p_scl_filter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_filt) |-> ($past(scl_in) == scl_filt));

  p_sda_filter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_filt) |-> ($past(sda_in) == sda_filt));
endmodule

bind scl_timegen scl_tg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in), .sda_in(sda_in),
  .scl_oe(scl_oe), .hi_strb(hi_strb), .lo_strb(lo_strb), .sda_ok(sda_ok),
  .scl_filt(scl_filt), .sda_filt(sda_filt)
);

// File: tb/scl_timegen_bench.sv
module scl_timegen_bench;
  localparam int CLK_P = 10;
  localparam int CW = 16, SW = 8, HW = 16;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [1:0] mode = 2'd1;
  logic [CW-1:0] ss_hcnt = 10, ss_lcnt = 12, fs_hcnt = 5, fs_lcnt = 6, hs_hcnt = 2, hs_lcnt = 3;
  logic [SW-1:0] fs_spklen = 2, hs_spklen = 1;
  logic [HW-1:0] sda_hold = 3;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic scl_oe, hi_strb, lo_strb, sda_ok, scl_filt, sda_filt;

  int checks = 0, errors = 0, cyc = 0;

  scl_timegen #(.CW(CW), .SW(SW), .HW(HW)) u_scl_timegen (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_run, m_ph, m_rem, m_hact, m_hcnt;
  bit  m_hs, m_ls, m_scl = 1, m_sda = 1;
  bit  scl_hist[$], sda_hist[$];

  function automatic int spk_now();
    return (mode == 2'd3) ? int'(hs_spklen) : int'(fs_spklen);
  endfunction
  function automatic int hi_now();
    case (mode)
      2'd3: return int'(hs_hcnt) + spk_now() + 7;
      2'd2: return int'(fs_hcnt) + spk_now() + 7;
      default: return int'(ss_hcnt) + spk_now() + 7;
    endcase
  endfunction
  function automatic int lo_now();
    case (mode)
      2'd3: return int'(hs_lcnt) + 1;
      2'd2: return int'(fs_lcnt) + 1;
      default: return int'(ss_lcnt) + 1;
    endcase
  endfunction
  function automatic bit settled(ref bit h[$], input bit v, input int n);
    if (h.size() < n) return 0;
    for (int i = 0; i < n; i++) if (h[i] != v) return 0;
    return 1;
  endfunction

  initial begin
    m_run = 0; m_ph = 0; m_rem = 0; m_hact = 0; m_hcnt = 0; m_hs = 0; m_ls = 0;
  end

  always @(posedge clk) begin
    bit ld_lo;
    int n;
    ld_lo = 0;
    if (!rst_n) begin
      scl_hist.delete(); sda_hist.delete(); m_scl = 1; m_sda = 1;
    end else begin
      n = (spk_now() < 1) ? 1 : spk_now();
      scl_hist.push_front(scl_in); sda_hist.push_front(sda_in);
      if (scl_hist.size() > 300) begin void'(scl_hist.pop_back()); void'(sda_hist.pop_back()); end
      if (m_scl != scl_in && settled(scl_hist, scl_in, n)) m_scl = scl_in;
      if (m_sda != sda_in && settled(sda_hist, sda_in, n)) m_sda = sda_in;
    end
    if (!rst_n || !enable) begin
      m_run = 0; m_ph = 0; m_rem = 0; m_hs = 0; m_ls = 0; m_hact = 0; m_hcnt = 0;
    end else begin
      m_hs = 0; m_ls = 0;
      if (m_run == 0) begin m_run = 1; m_ph = 0; m_rem = hi_now(); m_hs = 1; end
      else if (m_rem == 1) begin
        if (m_ph == 0) begin m_ph = 1; m_rem = lo_now(); m_ls = 1; ld_lo = 1; end
        else begin m_ph = 0; m_rem = hi_now(); m_hs = 1; end
      end else m_rem--;
      if (ld_lo) begin m_hact = 1; m_hcnt = int'(sda_hold); end
      else if (m_hact != 0) begin
        if (m_hcnt == 0) m_hact = 0; else m_hcnt--;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit e_oe, e_ok;
    e_oe = (m_run != 0) && (m_ph == 1);
    e_ok = (m_hact != 0) && (m_hcnt == 0);
    chk(scl_oe == e_oe, "R1 R2 R3 R4 R6 R10 scl_oe", scl_oe, e_oe);
    chk(hi_strb == m_hs, "R7 hi_strb", hi_strb, m_hs);
    chk(lo_strb == m_ls, "R7 lo_strb", lo_strb, m_ls);
    chk(sda_ok == e_ok, "R8 sda_ok", sda_ok, e_ok);
    chk(scl_filt == m_scl, "R9 R5 scl_filt", scl_filt, m_scl);
    chk(sda_filt == m_sda, "R9 R5 sda_filt", sda_filt, m_sda);
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- directed measurements ----------------
  task automatic meas_low(output int n);
    n = 0;
    do @(negedge clk); while (!lo_strb);
    while (scl_oe) begin n++; @(negedge clk); end
  endtask
  task automatic meas_high(output int n);
    n = 0;
    do @(negedge clk); while (!hi_strb);
    while (!scl_oe) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(scl_oe == 0 && hi_strb == 0 && lo_strb == 0 && sda_ok == 0, "R1 reset outputs", scl_oe, 0);
    chk(scl_filt == 1 && sda_filt == 1, "R9 reset filters", scl_filt, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(scl_oe == 0, "R1 idle while disabled", scl_oe, 0);
    enable = 1'b1;
    meas_high(n); chk(n == 19, "R2 first high std", n, 19);
    meas_low(n);  chk(n == 13, "R3 low std", n, 13);

    // R6: rewrite low count in first cycle of a low phase
    do @(negedge clk); while (!lo_strb);
    ss_lcnt = 4; n = 0;
    while (scl_oe) begin n++; @(negedge clk); end
    chk(n == 13, "R6 running phase unchanged", n, 13);
    meas_low(n); chk(n == 5, "R6 next phase uses new count", n, 5);

    mode = 2'd2;
    meas_high(n); chk(n == 14, "R4 fast high", n, 14);
    meas_low(n);  chk(n == 7, "R4 fast low", n, 7);
    mode = 2'd3;
    meas_high(n); chk(n == 10, "R5 hs high with hs spike", n, 10);
    meas_low(n);  chk(n == 4, "R4 hs low", n, 4);
    mode = 2'd0;
    meas_high(n); chk(n == 19, "R4 mode 0 as standard", n, 19);

    // R8: hold of zero pulses in first low cycle
    sda_hold = 0;
    do @(negedge clk); while (!lo_strb);
    do @(negedge clk); while (!lo_strb);
    chk(sda_ok == 1, "R8 zero hold same cycle", sda_ok, 1);
    sda_hold = 2;
    repeat (60) @(negedge clk);

    // R10: disable in first low cycle
    mode = 2'd1;
    do @(negedge clk); while (!lo_strb);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_oe == 0, "R10 released after disable", scl_oe, 0);
    repeat (3) @(negedge clk);
    enable = 1'b1;
    meas_high(n); chk(n == 19, "R10 full high after re-enable", n, 19);

    // R9: filter with fs spike length 3
    fs_spklen = 3;
    @(negedge clk); scl_in = 1'b0;
    repeat (2) @(negedge clk); scl_in = 1'b1;
    repeat (2) @(negedge clk);
    chk(scl_filt == 1, "R9 short glitch ignored", scl_filt, 1);
    scl_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl_filt == 0, "R9 full-length pulse passes", scl_filt, 0);
    scl_in = 1'b1;
    repeat (4) @(negedge clk);
    // R5: hs spike length 1 lets a single-sample pulse through on SDA
    mode = 2'd3;
    @(negedge clk); sda_in = 1'b0;
    @(negedge clk); sda_in = 1'b1;
    chk(sda_filt == 0, "R5 hs spike length on sda", sda_filt, 0);
    repeat (40) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule